// File: doc/BRIEF.md
# Bit-Selected Partitioned Lookup Front End

This block sits in front of a ternary match array that is cut into equal, contiguous blocks of entries. Search power grows with the number of entries that take part in a search, so each lookup enables only part of the array. For each destination address presented, the block picks K bits out of the upper 16 address bits to form a bucket number. It looks that bucket up in a programmable table of block masks, and ORs the result with a mask of blocks that every lookup searches. Those blocks hold the prefixes that are very short or very long.

The per-block search-enable vector leaves the block one cycle after the address arrives. It comes with the bucket number and the number of entries that the search will touch. Which address bits form the bucket, and which blocks each bucket covers, are both loaded through simple write ports. After reset the bucket is the lowest K bits of the upper 16-bit field.

Top module: `bsel_lookup_front`

## Requirements
- R1: During and after reset en_valid, en_vec and en_count are 0. Every bucket's block mask is cleared and selector i points at field bit i.
- R2: A lookup presented with lk_valid high in cycle t yields en_valid high in cycle t+1. In a cycle that follows no lookup, en_valid, en_vec and en_count are all 0.
- R3: The field is lk_addr[ADDR_W-1:ADDR_W-16], and field bit j is lk_addr[ADDR_W-16+j]. With the reset selectors, en_bucket equals field bits K-1..0.
- R4: Writing sel_src (a 4-bit field bit index) with sel_we at position sel_pos makes bucket bit sel_pos take field bit sel_src. This applies to every later lookup.
- R5: en_vec is the block mask stored for the selected bucket, ORed with the always_mask value present alongside the lookup.
- R6: Blocks set in always_mask are enabled on every lookup, including one whose bucket mask is empty.
- R7: en_count equals the number of ones in en_vec times BLK_ENTRIES. This holds from zero blocks up to all NBLK blocks.
- R8: A bucket mask write (map_we, map_bkt, map_mask) in the same cycle as a lookup to that bucket is not seen by that lookup. It is seen by a lookup in the next cycle.
- R9: Address bits below the upper 16-bit field have no effect on en_bucket, en_vec or en_count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_we | input | 1 | Write strobe for one bit selector |
| sel_pos | input | clog2(K) | Bucket bit whose selector is written |
| sel_src | input | 4 | Field bit index loaded into the selector |
| map_we | input | 1 | Write strobe for one bucket mask |
| map_bkt | input | K | Bucket whose mask is written |
| map_mask | input | NBLK | New block mask for that bucket |
| always_mask | input | NBLK | Blocks searched on every lookup |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | ADDR_W | Destination address |
| en_valid | output | 1 | Result valid, one cycle after lk_valid |
| en_bucket | output | K | Bucket number that was used |
| en_vec | output | NBLK | Per-block search enables |
| en_count | output | clog2(NBLK*BLK_ENTRIES+1) | Entries that will be searched |

## Verification
Addresses whose low field bits walk through several buckets show that the reset bit choice works. A scrambled selector set (bits 15, 8, 3 and 0) shows that the selection follows the programmed indices rather than fixed wiring. Addresses that differ only below the field must give identical results, which separates field-only hashing from use of the whole address. An empty bucket combined with a nonzero always-search mask, a bucket covering all blocks, and a mask write in the same cycle as a lookup pin down the OR merge, the full-scale entry count, and read-before-write ordering of the table.

// File: rtl/bsel_pkg.sv
package bsel_pkg;
  localparam int FIELD_W = 16;
  localparam int IDX_W   = 4;
  typedef logic [IDX_W-1:0] field_idx_t;
endpackage

// File: rtl/bsel_index_gen.sv
// Holds the K bit selectors and forms the bucket number from the address field.
module bsel_index_gen
  import bsel_pkg::*;
#(
  parameter int K     = 4,
  parameter int POS_W = (K > 1) ? $clog2(K) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sel_we,
  input  logic [POS_W-1:0]   sel_pos,
  input  field_idx_t         sel_src,
  input  logic [FIELD_W-1:0] field,
  output logic [K-1:0]       bucket
);
  field_idx_t sel_q [K];

  for (genvar i = 0; i < K; i++) begin : g_sel
    always_ff @(posedge clk) begin
      if (!rst_n)
        sel_q[i] <= field_idx_t'(i);
      else if (sel_we && (sel_pos == POS_W'(i)))
        sel_q[i] <= sel_src;
    end
    assign bucket[i] = field[sel_q[i]];
  end
endmodule

// File: rtl/bucket_mask_table.sv
// One block mask per bucket; the read port returns the value before any same-cycle write.
module bucket_mask_table #(
  parameter int K    = 4,
  parameter int NBLK = 16,
  localparam int NBKT = 1 << K
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [K-1:0]    wr_bkt,
  input  logic [NBLK-1:0] wr_mask,
  input  logic [K-1:0]    rd_bkt,
  output logic [NBLK-1:0] rd_mask
);
  logic [NBLK-1:0] tbl [NBKT];

  for (genvar b = 0; b < NBKT; b++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n)
        tbl[b] <= '0;
      else if (wr_en && (wr_bkt == K'(b)))
        tbl[b] <= wr_mask;
    end
  end

  assign rd_mask = tbl[rd_bkt];
endmodule

// File: rtl/enable_merge.sv
// Merges the bucket mask with the always-search set and sizes the search.
module enable_merge #(
  parameter int NBLK        = 16,
  parameter int BLK_ENTRIES = 8192,
  parameter int CNT_W       = $clog2(NBLK * BLK_ENTRIES + 1)
) (
  input  logic [NBLK-1:0]  bucket_mask,
  input  logic [NBLK-1:0]  always_mask,
  output logic [NBLK-1:0]  merged_vec,
  output logic [CNT_W-1:0] merged_count
);
  function automatic logic [CNT_W-1:0] entries_for(input logic [NBLK-1:0] v);
    int n;
    n = 0;
    for (int b = 0; b < NBLK; b++)
      if (v[b]) n++;
    return CNT_W'(n * BLK_ENTRIES);
  endfunction

  assign merged_vec   = bucket_mask | always_mask;
  assign merged_count = entries_for(merged_vec);
endmodule

// File: rtl/bsel_lookup_front.sv
module bsel_lookup_front
  import bsel_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int K           = 4,
  parameter int NBLK        = 16,
  parameter int BLK_ENTRIES = 8192,
  localparam int POS_W      = (K > 1) ? $clog2(K) : 1,
  localparam int CNT_W      = $clog2(NBLK * BLK_ENTRIES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_we,
  input  logic [POS_W-1:0]  sel_pos,
  input  logic [IDX_W-1:0]  sel_src,
  input  logic              map_we,
  input  logic [K-1:0]      map_bkt,
  input  logic [NBLK-1:0]   map_mask,
  input  logic [NBLK-1:0]   always_mask,
  input  logic              lk_valid,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              en_valid,
  output logic [K-1:0]      en_bucket,
  output logic [NBLK-1:0]   en_vec,
  output logic [CNT_W-1:0]  en_count
);
  logic [FIELD_W-1:0] addr_field;
  logic               unused_low_bits;
  logic [K-1:0]       bucket_w;
  logic [NBLK-1:0]    map_rd_mask;
  logic [NBLK-1:0]    merged_vec;
  logic [CNT_W-1:0]   merged_count;

  assign addr_field      = lk_addr[ADDR_W-1 -: FIELD_W];
  assign unused_low_bits = ^lk_addr[ADDR_W-FIELD_W-1:0];

  bsel_index_gen #(.K(K), .POS_W(POS_W)) u_index (
    .clk(clk), .rst_n(rst_n), .sel_we(sel_we), .sel_pos(sel_pos),
    .sel_src(field_idx_t'(sel_src)), .field(addr_field), .bucket(bucket_w)
  );

  bucket_mask_table #(.K(K), .NBLK(NBLK)) u_table (
    .clk(clk), .rst_n(rst_n), .wr_en(map_we), .wr_bkt(map_bkt),
    .wr_mask(map_mask), .rd_bkt(bucket_w), .rd_mask(map_rd_mask)
  );

  enable_merge #(.NBLK(NBLK), .BLK_ENTRIES(BLK_ENTRIES), .CNT_W(CNT_W)) u_merge (
    .bucket_mask(map_rd_mask), .always_mask(always_mask),
    .merged_vec(merged_vec), .merged_count(merged_count)
  );

  always_ff @(posedge clk) begin
    if (!rst_n || !lk_valid) begin
      en_valid  <= 1'b0;
      en_bucket <= '0;
      en_vec    <= '0;
      en_count  <= '0;
    end else begin
      en_valid  <= 1'b1;
      en_bucket <= bucket_w;
      en_vec    <= merged_vec;
      en_count  <= merged_count;
    end
  end
endmodule

// File: rtl/bsel_lookup_chk.sv
module bsel_lookup_chk #(
  parameter int NBLK        = 16,
  parameter int BLK_ENTRIES = 8192,
  parameter int CNT_W       = 18
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lk_valid,
  input logic [NBLK-1:0]  always_mask,
  input logic [NBLK-1:0]  map_rd_mask,
  input logic             en_valid,
  input logic [NBLK-1:0]  en_vec,
  input logic [CNT_W-1:0] en_count
);
  p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> en_valid);

  p_idle_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> (!en_valid && en_vec == '0 && en_count == '0));

  p_merge_r5: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> (en_vec == ($past(map_rd_mask) | $past(always_mask))));

  p_always_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> ((en_vec & $past(always_mask)) == $past(always_mask)));

  p_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
    en_valid |-> (en_count == CNT_W'($countones(en_vec) * BLK_ENTRIES)));
endmodule

bind bsel_lookup_front bsel_lookup_chk #(
  .NBLK(NBLK), .BLK_ENTRIES(BLK_ENTRIES), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .always_mask(always_mask),
  .map_rd_mask(map_rd_mask), .en_valid(en_valid), .en_vec(en_vec),
  .en_count(en_count)
);

// File: tb/test_bsel_lookup_front.sv
`timescale 1ns/1ps
module test_bsel_lookup_front;
  localparam int ADDR_W      = 32;
  localparam int K           = 4;
  localparam int NBLK        = 16;
  localparam int BLK_ENTRIES = 8192;
  localparam int NBKT        = 1 << K;
  localparam int POS_W       = 2;
  localparam int CNT_W       = $clog2(NBLK * BLK_ENTRIES + 1);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              sel_we = 1'b0;
  logic [POS_W-1:0]  sel_pos = '0;
  logic [3:0]        sel_src = '0;
  logic              map_we = 1'b0;
  logic [K-1:0]      map_bkt = '0;
  logic [NBLK-1:0]   map_mask = '0;
  logic [NBLK-1:0]   always_mask = '0;
  logic              lk_valid = 1'b0;
  logic [ADDR_W-1:0] lk_addr = '0;
  logic              en_valid;
  logic [K-1:0]      en_bucket;
  logic [NBLK-1:0]   en_vec;
  logic [CNT_W-1:0]  en_count;

  always #2 clk = ~clk;

  bsel_lookup_front i_bsel_lookup_front (
    .clk(clk), .rst_n(rst_n), .sel_we(sel_we), .sel_pos(sel_pos),
    .sel_src(sel_src), .map_we(map_we), .map_bkt(map_bkt), .map_mask(map_mask),
    .always_mask(always_mask), .lk_valid(lk_valid), .lk_addr(lk_addr),
    .en_valid(en_valid), .en_bucket(en_bucket), .en_vec(en_vec),
    .en_count(en_count)
  );

  typedef struct {
    logic [K-1:0]     bkt;
    logic [NBLK-1:0]  vec;
    logic [CNT_W-1:0] cnt;
    string            tag;
  } exp_t;

  exp_t            sb[$];
  int              sel_m [K];
  logic [NBLK-1:0] map_m [NBKT];
  int              n_chk = 0;
  int              n_bad = 0;
  bit              mon_on = 1'b0;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [K-1:0] ref_bucket(input logic [ADDR_W-1:0] a);
    logic [K-1:0] r;
    r = '0;
    for (int i = 0; i < K; i++) r[i] = a[ADDR_W - 16 + sel_m[i]];
    return r;
  endfunction

  function automatic logic [CNT_W-1:0] ref_count(input logic [NBLK-1:0] v);
    int n;
    n = 0;
    for (int b = 0; b < NBLK; b++) n += int'(v[b]);
    return CNT_W'(n * BLK_ENTRIES);
  endfunction

  function automatic exp_t predict(input logic [ADDR_W-1:0] a, input string tag);
    exp_t e;
    e.bkt = ref_bucket(a);
    e.vec = map_m[e.bkt] | always_mask;
    e.cnt = ref_count(e.vec);
    e.tag = tag;
    return e;
  endfunction

  task automatic do_lookup(input logic [ADDR_W-1:0] a, input string tag);
    sb.push_back(predict(a, tag));
    lk_valid = 1'b1;
    lk_addr  = a;
    @(negedge clk);
    lk_valid = 1'b0;
  endtask

  task automatic set_sel(input int pos, input int src);
    sel_we = 1'b1; sel_pos = POS_W'(pos); sel_src = 4'(src);
    @(negedge clk);
    sel_we = 1'b0;
    sel_m[pos] = src;
  endtask

  task automatic set_map(input int b, input logic [NBLK-1:0] m);
    map_we = 1'b1; map_bkt = K'(b); map_mask = m;
    @(negedge clk);
    map_we = 1'b0;
    map_m[b] = m;
  endtask

  task automatic lookup_and_write(input logic [ADDR_W-1:0] a, input int b,
                                  input logic [NBLK-1:0] m, input string tag);
    sb.push_back(predict(a, tag));
    lk_valid = 1'b1; lk_addr = a;
    map_we = 1'b1; map_bkt = K'(b); map_mask = m;
    @(negedge clk);
    lk_valid = 1'b0; map_we = 1'b0;
    map_m[b] = m;
  endtask

  // Monitor: pops one expected item per valid result, checks idle cycles are zero.
  always @(negedge clk) begin
    if (mon_on) begin
      if (en_valid) begin
        if (sb.size() == 0) begin
          check(1'b0, "R2", "unexpected en_valid", 64'(en_valid), 64'd0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(en_bucket == e.bkt, e.tag, "en_bucket", 64'(en_bucket), 64'(e.bkt));
          check(en_vec == e.vec, e.tag, "en_vec", 64'(en_vec), 64'(e.vec));
          check(en_count == e.cnt, e.tag, "en_count", 64'(en_count), 64'(e.cnt));
        end
      end else begin
        check(en_vec == '0 && en_count == '0, "R2", "idle outputs",
              {30'd0, en_vec, en_count}, 64'd0);
      end
    end
  end

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL R2 watchdog expired: actual 1 expected 0");
    finish_run();
  end

  initial begin
    for (int i = 0; i < K; i++) sel_m[i] = i;
    for (int b = 0; b < NBKT; b++) map_m[b] = '0;

    repeat (3) @(negedge clk);
    // R1: outputs cleared while in reset
    check(en_valid == 1'b0, "R1", "en_valid in reset", 64'(en_valid), 64'd0);
    check(en_vec == '0, "R1", "en_vec in reset", 64'(en_vec), 64'd0);
    check(en_count == '0, "R1", "en_count in reset", 64'(en_count), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    mon_on = 1'b1;

    // R1: cleared table, default selectors
    do_lookup(32'hABCD_1234, "R1");
    do_lookup(32'h0000_0000, "R1");

    for (int b = 0; b < NBKT; b++)
      set_map(b, (NBLK'(1) << b) | ((b % 2) == 1 ? 16'h0F00 : 16'h0000));

    // R3: default selection, back-to-back
    do_lookup(32'h0003_0000, "R3");
    do_lookup(32'hFFF5_FFFF, "R3");
    do_lookup(32'h1230_0000, "R3");
    do_lookup(32'h000F_0000, "R3");
    do_lookup(32'h8ACE_0000, "R5");

    // R9: bits below the field do not matter
    do_lookup(32'h0007_0000, "R9");
    do_lookup(32'h0007_FFFF, "R9");
    do_lookup(32'h0007_A5A5, "R9");

    // R2: idle gap
    repeat (3) @(negedge clk);

    // R6: always-search blocks on an empty bucket and a populated one
    always_mask = 16'hC000;
    set_map(9, 16'h0000);
    do_lookup(32'h0009_0000, "R6");
    do_lookup(32'h0002_0000, "R6");

    // R4: scrambled selectors 15, 8, 3, 0
    set_sel(0, 15);
    set_sel(1, 8);
    set_sel(2, 3);
    set_sel(3, 0);
    do_lookup(32'h8000_0000, "R4");
    do_lookup(32'h0109_0000, "R4");
    do_lookup(32'h7EF6_0000, "R4");
    do_lookup(32'hFFFF_0000, "R4");

    // R8: write in the same cycle as a lookup to that bucket
    always_mask = 16'h0000;
    lookup_and_write(32'h0109_0000, 14, 16'h00F0, "R8");
    do_lookup(32'h0109_0000, "R8");

    // R7: full and empty extremes of the entry count
    set_map(15, 16'hFFFF);
    do_lookup(32'hFFFF_0000, "R7");
    set_map(0, 16'h0000);
    do_lookup(32'h0000_0000, "R7");

    repeat (3) @(negedge clk);
    check(sb.size() == 0, "R2", "results missing", 64'(sb.size()), 64'd0);
    finish_run();
  end
endmodule